// File: doc/BRIEF.md
# Random Word Repetition Guard

This block sits on the path where 128-bit random words leave a receive buffer and continue toward their consumers. Words flow through it unchanged and without delay. The valid and data signals go straight from the input side to the output side, and the ready signal goes straight back from the output side to the input side. While the words flow, the block watches every word that is actually accepted, meaning valid and ready are both high in the same cycle.

For each accepted word it takes the low 64 bits (bits 63:0) and compares them with the same slice of the previous accepted word. If the two slices are identical, the random source has produced a repeat. The block then raises a fatal error flag that stays up until reset or until the module enable is dropped. The first word accepted after enable is never compared, because no earlier slice exists yet. Comparing half the word keeps the comparator and the history register small, and still makes a repeat highly unlikely to pass unnoticed.

Top module: `rng_repeat_guard`

## Requirements
- R1: `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle, with no register in between.
- R2: `in_ready` equals `out_ready` in the same cycle.
- R3: After reset, `err` is 0 and no slice counts as captured, so the first word accepted after reset cannot raise `err`.
- R4: The first word accepted after `enable` rises is stored but not compared, and never raises `err`.
- R5: When a word is accepted while `enable` is 1 and a previous slice is held, and its bits 63:0 equal the held bits 63:0, `err` reads 1 after the next rising clock edge.
- R6: Only bits 63:0 take part in the comparison. A word that differs from the previous one only in bits 127:64 still raises `err`. A difference in bit 0 alone is enough to prevent it.
- R7: A word offered with `out_ready` at 0 is not accepted. It is neither compared nor stored, so the next accepted word is compared against the last word that was actually accepted.
- R8: Once set, `err` stays 1 while `enable` stays 1, whatever words follow.
- R9: `enable` at 0 during a clock edge clears `err` and forgets the stored slice. The first word accepted after re-enable is not compared, even if it equals the forgotten slice.
- R10: While `enable` is 0, accepted repeats never raise `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Module enable; low clears the error and the stored slice |
| in_valid | input | 1 | Word offered by the receive buffer |
| in_data | input | 128 | Random word from the receive buffer |
| in_ready | output | 1 | Ready returned to the receive buffer (copy of `out_ready`) |
| out_valid | output | 1 | Word offered downstream (copy of `in_valid`) |
| out_data | output | 128 | Word passed downstream (copy of `in_data`) |
| out_ready | input | 1 | Downstream ready |
| err | output | 1 | Sticky fatal repeat error |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a known 0/1 value after reset. This matters most for `enable` and the handshake pair, because the properties use them to decide which edges count as an accepted word. The bench drives every input at the falling edge, never leaves one undefined once reset is released, and changes `enable` only on whole-cycle boundaries. Each rising edge therefore sees one settled value for accept and enable, which is what the rise-cause and first-word properties rely on.

// File: rtl/rrg_pkg.sv
package rrg_pkg;

  // Default geometry of the guarded stream
  parameter int unsigned WORD_W_DEF  = 128;
  parameter int unsigned CMP_LSB_DEF = 0;
  parameter int unsigned CMP_W_DEF   = 64;
  parameter int unsigned LANE_W_DEF  = 16;

  // Widest lane the comparator function accepts
  parameter int unsigned LANE_MAX_W  = 64;

  // Returns 1 when the low w bits of a and b differ anywhere
  function automatic logic lane_differs(input logic [LANE_MAX_W-1:0] a,
                                        input logic [LANE_MAX_W-1:0] b,
                                        input int unsigned w);
    logic d;
    d = 1'b0;
    for (int unsigned i = 0; i < LANE_MAX_W; i++) begin
      if (i < w) d = d | (a[i] ^ b[i]);
    end
    return d;
  endfunction

  // A repeat counts only when the guard is on, a word moves and history exists
  function automatic logic repeat_hit(input logic en,
                                      input logic moved,
                                      input logic have_prev,
                                      input logic same);
    return en & moved & have_prev & same;
  endfunction

endpackage

// File: rtl/rrg_cmp.sv
module rrg_cmp #(
  parameter int unsigned CMP_W  = rrg_pkg::CMP_W_DEF,
  parameter int unsigned LANE_W = rrg_pkg::LANE_W_DEF
) (
  input  logic [CMP_W-1:0] cur_i,
  input  logic [CMP_W-1:0] prev_i,
  output logic             same_o
);
  import rrg_pkg::*;

  localparam int unsigned NUM_LANES = CMP_W / LANE_W;
  localparam int unsigned LMW       = LANE_MAX_W;

  logic [NUM_LANES-1:0] lane_diff;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cur_lane, prev_lane;
    assign cur_lane  = cur_i[g*LANE_W +: LANE_W];
    assign prev_lane = prev_i[g*LANE_W +: LANE_W];
    assign lane_diff[g] = lane_differs(LMW'(cur_lane), LMW'(prev_lane), LANE_W);
  end

  assign same_o = ~|lane_diff;

endmodule

// File: rtl/rrg_hist.sv
module rrg_hist #(
  parameter int unsigned CMP_W = rrg_pkg::CMP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             take_i,
  input  logic [CMP_W-1:0] slice_i,
  output logic [CMP_W-1:0] prev_o,
  output logic             prev_vld_o
);

  logic [CMP_W-1:0] prev_q;
  logic             vld_q;

  // Stored slice follows every accepted word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_q <= '0;
    else if (take_i) prev_q <= slice_i;
  end

  // History valid: set by an accepted word, dropped whenever disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= 1'b0;
    else if (!en_i) vld_q <= 1'b0;
    else if (take_i) vld_q <= 1'b1;
  end

  assign prev_o     = prev_q;
  assign prev_vld_o = vld_q;

endmodule

// File: rtl/rrg_sticky.sv
module rrg_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic hit_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (!en_i) flag_q <= 1'b0;
    else if (hit_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rng_repeat_guard.sv
module rng_repeat_guard #(
  parameter int unsigned WORD_W  = rrg_pkg::WORD_W_DEF,
  parameter int unsigned CMP_LSB = rrg_pkg::CMP_LSB_DEF,
  parameter int unsigned CMP_W   = rrg_pkg::CMP_W_DEF,
  parameter int unsigned LANE_W  = rrg_pkg::LANE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready,
  output logic              err
);
  import rrg_pkg::*;

  localparam int unsigned CMP_MSB = CMP_LSB + CMP_W - 1;

  // Named internal events, observed by the bound checker
  logic             accept_w;
  logic             same_w;
  logic             hit_w;
  logic             prev_vld_w;
  logic [CMP_W-1:0] slice_w;
  logic [CMP_W-1:0] prev_w;

  // Zero-latency pass-through
  assign out_valid = in_valid;
  assign out_data  = in_data;
  assign in_ready  = out_ready;

  assign accept_w = in_valid & out_ready;
  assign slice_w  = in_data[CMP_MSB:CMP_LSB];

  rrg_hist #(.CMP_W(CMP_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (enable),
    .take_i     (accept_w),
    .slice_i    (slice_w),
    .prev_o     (prev_w),
    .prev_vld_o (prev_vld_w)
  );

  rrg_cmp #(.CMP_W(CMP_W), .LANE_W(LANE_W)) u_cmp (
    .cur_i  (slice_w),
    .prev_i (prev_w),
    .same_o (same_w)
  );

  assign hit_w = repeat_hit(enable, accept_w, prev_vld_w, same_w);

  rrg_sticky u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (enable),
    .hit_i  (hit_w),
    .flag_o (err)
  );

endmodule

// File: rtl/rrg_checker.sv
module rrg_checker #(
  parameter int unsigned WORD_W = rrg_pkg::WORD_W_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_ready,
  input logic              err,
  input logic              accept,
  input logic              hit
);

  // Checker-side view: has a word been accepted since the guard was enabled
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (!enable) seen_q <= 1'b0;
    else if (accept)  seen_q <= 1'b1;
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n) (out_valid == in_valid) && (out_data == in_data)); // R1
  AST_READY_FWD: assert property (@(posedge clk) disable iff (!rst_n) in_ready == out_ready); // R2
  AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (enable && accept && !seen_q) |=> !$rose(err)); // R4
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> $past(hit)); // R5
  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) (!in_valid || !out_ready) |=> !$rose(err)); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err && enable) |=> err); // R8
  AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !err); // R9
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!enable && accept) |=> !err); // R10

endmodule

bind rng_repeat_guard rrg_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .err       (err),
  .accept    (accept_w),
  .hit       (hit_w)
);

// File: tb/sim_rng_repeat_guard.sv
module sim_rng_repeat_guard;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_ready = 1'b0;
  logic         err;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rng_repeat_guard u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .err(err)
  );

  task automatic chk1(input logic got, input logic exp, input string req);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic chkw(input logic [127:0] got, input logic [127:0] exp, input string req);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One cycle: offer a word, check pass-through mid-cycle, end after the edge
  task automatic push(input logic [127:0] w, input logic rdy);
    @(negedge clk);
    in_valid = 1'b1; in_data = w; out_ready = rdy;
    #1;
    chkw(out_data, w, "R1 data");
    chk1(out_valid, 1'b1, "R1 valid");
    chk1(in_ready, rdy, "R2 ready");
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
  endtask

  // Drop enable across one edge, then raise it again
  task automatic toggle_enable();
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    chk1(err, 1'b0, "R9 cleared");
    enable = 1'b1;
  endtask

  localparam logic [127:0] WA = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] WB = 128'hdead_beef_0000_1111_2222_3333_4444_5555;
  localparam logic [127:0] WC = 128'h5a5a_5a5a_a5a5_a5a5_0f0f_0f0f_f0f0_f0f0;
  localparam logic [127:0] WD = 128'h1111_2222_3333_4444_5555_6666_7777_8888;

  task automatic t_reset();
    #1;
    chk1(err, 1'b0, "R3 err in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk1(err, 1'b0, "R3 err after reset");
  endtask

  task automatic t_passthrough();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1; in_data = WD;
    #1;
    chk1(out_valid, 1'b0, "R1 valid low");
    chkw(out_data, WD, "R1 data idle");
    chk1(in_ready, 1'b1, "R2 ready high");
    out_ready = 1'b0;
    #1;
    chk1(in_ready, 1'b0, "R2 ready low");
  endtask

  task automatic t_first_and_repeat();
    @(negedge clk); enable = 1'b1;
    push(WA, 1'b1);
    chk1(err, 1'b0, "R4 first word");
    push(WB, 1'b1);
    chk1(err, 1'b0, "R5 distinct word");
    push(WB, 1'b1);
    chk1(err, 1'b1, "R5 repeat");
    push(WC, 1'b1);
    chk1(err, 1'b1, "R8 sticky");
    repeat (3) @(negedge clk);
    chk1(err, 1'b1, "R8 sticky idle");
  endtask

  task automatic t_disable();
    toggle_enable();
    push(WC, 1'b1); // equals the forgotten slice
    chk1(err, 1'b0, "R9 history forgotten");
    push(WC, 1'b1);
    chk1(err, 1'b1, "R5 repeat after re-enable");
  endtask

  task automatic t_slice();
    toggle_enable();
    push(WA, 1'b1);
    push(WA ^ 128'h1, 1'b1);
    chk1(err, 1'b0, "R6 bit 0 differs");
    push((WA ^ 128'h1) ^ {64'hffff_0000_ffff_0000, 64'h0}, 1'b1);
    chk1(err, 1'b1, "R6 upper half ignored");
  endtask

  task automatic t_not_accepted();
    toggle_enable();
    push(WB, 1'b1);
    push(WB, 1'b0);
    chk1(err, 1'b0, "R7 refused repeat");
    push(WD, 1'b1);
    push(WC, 1'b0);
    push(WC, 1'b1);
    chk1(err, 1'b0, "R7 refused word not stored");
    push(WC, 1'b1);
    chk1(err, 1'b1, "R7 accepted repeat");
  endtask

  task automatic t_disabled();
    @(negedge clk); enable = 1'b0;
    push(WD, 1'b1);
    push(WD, 1'b1);
    chk1(err, 1'b0, "R10 disabled repeat");
    push(WD, 1'b1);
    chk1(err, 1'b0, "R10 disabled repeat again");
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_first_and_repeat();
    t_disable();
    t_slice();
    t_not_accepted();
    t_disabled();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule